// File: doc/BRIEF.md
# Command-Driven Seeded Random Word Generator

This block produces blocks of pseudo-random words on request from software over a 32-bit register bus. An internal 32-bit mixing state is seeded by folding an external entropy word into it for a fixed number of cycles. A generate command then advances the state once per output word and fills a bank of eight result words. The result is either four words (128 bits) or eight words (256 bits). The entropy input is a stub for a physical noise source. The mixer is a Galois LFSR, so the output is deterministic given the entropy seen during seeding. It is not meant to be of cryptographic quality.

Software drives the block with three command codes and polls a status word. It can also wait for a ready flag, which is set whether or not the interrupt is enabled. The block seeds itself when it leaves reset. It can reseed on command, and it reseeds by itself once a programmable number of 16-byte units has been produced. An interrupt line combines the two sticky flags with per-source enables and a global enable.

Top module: `seeded_rng`

## Requirements
- R1: After reset the status word (0x04) first reads 0x80000000, meaning reseeding is set and seeded is clear. Within SEED_CYCLES cycles it reads 0x00000200, with seeded on bit 9 and generating (bit 30) and reseeding (bit 31) both 0. Once set, seeded never clears until the next reset.
- R2: The identification word at 0xF0 reads 0x000046BC.
- R3: The mixing step is s' = {s[30:0],0} XOR (s[31] ? 0x04C11DB7 : 0). Writing 1 to the command word (0x00) with mode bit 3 (word 0x08) set to 1 advances the state eight times. Each advanced value is stored in turn into result words 0x20, 0x24, …, 0x3C.
- R4: With mode bit 3 at 0, a generate advances the state four times into words 0x20–0x2C and writes zero to words 0x30–0x3C.
- R5: Bit 0 of the flag word (0x14) sets when a generate finishes, whatever the enables are. Writing 1 to it clears it. Writing 0 leaves it unchanged.
- R6: Bit 1 of the flag word sets whenever a seeding finishes, including the one after reset. It is cleared by writing 1.
- R7: Writing 2 to the command word starts a seeding. Reseeding (bit 31) is set while it runs. Every seeding lasts SEED_CYCLES cycles and, each cycle, sets s = s' XOR entropy_in. The state is 1 after reset.
- R8: A generate written while seeding is held and runs as soon as the seeding finishes.
- R9: While a generate runs, every command is ignored. A reseed written while seeding is ignored. Command values other than 0, 1 and 2 are ignored at all times.
- R10: Word 0x60 holds a limit L. Each 128-bit generate counts 1 unit and each 256-bit generate counts 2 units. When the count reaches L at the end of a generate, a seeding starts at once. Any seeding clears the count, and L = 0 disables the automatic reseed.
- R11: The interrupt enable word (0x10) has global enable on bit 31, seed-done enable on bit 1 and ready enable on bit 0. irq equals global AND ((bit 0 enable AND ready flag) OR (bit 1 enable AND seed flag)), registered one cycle later.
- R12: A read returns data on bus_rdata in the cycle after bus_rd. Unmapped offsets read 0. The mode word keeps only bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| entropy_in | input | DATA_W | Entropy word from the noise-source stub |
| irq | output | 1 | Interrupt request, registered |

## Verification
The bench builds the block with SEED_CYCLES set to 4 and keeps the other parameters at their defaults. With the shorter seeding, many seedings fit in a short run: the one after reset, commanded ones, a held generate and automatic ones. Each can be compared word for word against a model of the mixer that is driven by the same entropy values. The default eight-word bank lets both the 128-bit and 256-bit modes run, including the zeroed upper half. A limit of 3 units makes the automatic reseed fire on the second 256-bit request.

// File: rtl/seeded_rng_pkg.sv
package seeded_rng_pkg;

  // register offsets (software-visible map)
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_MODE = 8'h08;
  localparam logic [7:0] OFS_IEN  = 8'h10;
  localparam logic [7:0] OFS_IFLG = 8'h14;
  localparam logic [7:0] OFS_OUT0 = 8'h20;
  localparam logic [7:0] OFS_LIM  = 8'h60;
  localparam logic [7:0] OFS_ID   = 8'hF0;

  localparam logic [31:0] ID_CODE = 32'h0000_46BC;

  // bit positions software decodes
  localparam int unsigned BIT_SEEDED = 9;
  localparam int unsigned BIT_GEN    = 30;
  localparam int unsigned BIT_RESEED = 31;
  localparam int unsigned BIT_WIDE   = 3;
  localparam int unsigned BIT_IE_GLB = 31;
  localparam int unsigned BIT_IE_SD  = 1;
  localparam int unsigned BIT_IE_RDY = 0;

  typedef enum logic [1:0] {
    ST_SEED = 2'd0,
    ST_IDLE = 2'd1,
    ST_GEN  = 2'd2
  } rng_state_e;

endpackage

// File: rtl/seeded_rng_mixer.sv
module seeded_rng_mixer #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY = 32'h04C1_1DB7,
  parameter logic [W-1:0] INIT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         absorb,
  input  logic         advance,
  input  logic [W-1:0] entropy,
  output logic [W-1:0] next_word
);

  logic [W-1:0] st_q;
  logic [W-1:0] stepped;

  assign stepped   = {st_q[W-2:0], 1'b0} ^ (st_q[W-1] ? POLY : '0);
  assign next_word = stepped;

  always_ff @(posedge clk) begin
    if (rst)          st_q <= INIT;
    else if (absorb)  st_q <= stepped ^ entropy;
    else if (advance) st_q <= stepped;
  end

endmodule

// File: rtl/seeded_rng_ctrl.sv
module seeded_rng_ctrl
  import seeded_rng_pkg::*;
#(
  parameter int unsigned SEED_CYCLES = 16,
  parameter int unsigned WORDS       = 8,
  parameter int unsigned CNT_W       = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_gen,
  input  logic                     req_seed,
  input  logic                     mode_wide,
  input  logic [CNT_W-1:0]         limit,
  output logic                     absorb,
  output logic                     advance,
  output logic                     word_we,
  output logic                     word_zero,
  output logic [$clog2(WORDS)-1:0] word_idx,
  output logic                     seeded,
  output logic                     generating,
  output logic                     reseeding,
  output logic                     gen_done,
  output logic                     seed_done
);

  localparam int unsigned IDX_W = $clog2(WORDS);
  localparam int unsigned SC_W  = $clog2(SEED_CYCLES) + 1;
  localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(WORDS / 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);
  localparam logic [SC_W-1:0]  LAST_SC  = SC_W'(SEED_CYCLES - 1);

  rng_state_e       state_q;
  logic [SC_W-1:0]  sc_q;
  logic [IDX_W-1:0] idx_q;
  logic             wide_q;
  logic             pend_q;
  logic             seeded_q;
  logic [CNT_W-1:0] units_q;
  logic [CNT_W-1:0] units_next;
  logic             hit_limit;
  logic             last_seed;
  logic             last_word;

  always_comb begin
    absorb     = (state_q == ST_SEED);
    word_we    = (state_q == ST_GEN);
    word_zero  = !wide_q && (idx_q >= HALF_IDX);
    advance    = word_we && !word_zero;
    word_idx   = idx_q;
    last_seed  = (sc_q == LAST_SC);
    last_word  = (idx_q == LAST_IDX);
    units_next = units_q + (wide_q ? CNT_W'(2) : CNT_W'(1));
    hit_limit  = (limit != '0) && (units_next >= limit);
    seeded     = seeded_q;
    generating = (state_q == ST_GEN);
    reseeding  = (state_q == ST_SEED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_SEED;
      sc_q      <= '0;
      idx_q     <= '0;
      wide_q    <= 1'b0;
      pend_q    <= 1'b0;
      seeded_q  <= 1'b0;
      units_q   <= '0;
      gen_done  <= 1'b0;
      seed_done <= 1'b0;
    end else begin
      gen_done  <= 1'b0;
      seed_done <= 1'b0;
      case (state_q)
        ST_SEED: begin
          if (req_gen) pend_q <= 1'b1;
          sc_q <= sc_q + SC_W'(1);
          if (last_seed) begin
            sc_q      <= '0;
            seeded_q  <= 1'b1;
            seed_done <= 1'b1;
            units_q   <= '0;
            if (pend_q || req_gen) begin
              state_q <= ST_GEN;
              wide_q  <= mode_wide;
              idx_q   <= '0;
              pend_q  <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_IDLE: begin
          if (req_gen) begin
            state_q <= ST_GEN;
            wide_q  <= mode_wide;
            idx_q   <= '0;
          end else if (req_seed) begin
            state_q <= ST_SEED;
            sc_q    <= '0;
          end
        end
        ST_GEN: begin
          idx_q <= idx_q + IDX_W'(1);
          if (last_word) begin
            gen_done <= 1'b1;
            idx_q    <= '0;
            if (hit_limit) begin
              units_q <= '0;
              state_q <= ST_SEED;
              sc_q    <= '0;
            end else begin
              units_q <= units_next;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seeded_rng.sv
module seeded_rng
  import seeded_rng_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned WORDS       = 8,
  parameter int unsigned SEED_CYCLES = 16,
  parameter int unsigned CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] entropy_in,
  output logic              irq
);

  localparam int unsigned IDX_W = $clog2(WORDS);
  localparam logic [ADDR_W-1:0] OUT_SPAN = ADDR_W'(4 * WORDS);

  logic             req_gen, req_seed;
  logic             absorb, advance, word_we, word_zero;
  logic [IDX_W-1:0] word_idx;
  logic             seeded, generating, reseeding, gen_done, seed_done;
  logic [DATA_W-1:0] mix_word;

  logic             mode_wide_q;
  logic             ien_glb, ien_sd, ien_rdy;
  logic [1:0]       iflag_q;
  logic [CNT_W-1:0] limit_q;
  logic [DATA_W-1:0] word_mem [WORDS];

  logic [ADDR_W-1:0] rel_addr;
  logic              in_out;
  logic [IDX_W-1:0]  rd_idx;
  logic              wr_iflg;

  assign req_gen  = bus_wr && (bus_addr == ADDR_W'(OFS_CMD)) && (bus_wdata == DATA_W'(1));
  assign req_seed = bus_wr && (bus_addr == ADDR_W'(OFS_CMD)) && (bus_wdata == DATA_W'(2));
  assign wr_iflg  = bus_wr && (bus_addr == ADDR_W'(OFS_IFLG));
  assign rel_addr = bus_addr - ADDR_W'(OFS_OUT0);
  assign in_out   = (rel_addr < OUT_SPAN) && (rel_addr[1:0] == 2'b00);
  assign rd_idx   = rel_addr[IDX_W+1:2];

  seeded_rng_mixer #(.W(DATA_W)) u_mix (
    .clk       (clk),
    .rst       (rst),
    .absorb    (absorb),
    .advance   (advance),
    .entropy   (entropy_in),
    .next_word (mix_word)
  );

  seeded_rng_ctrl #(
    .SEED_CYCLES (SEED_CYCLES),
    .WORDS       (WORDS),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_gen    (req_gen),
    .req_seed   (req_seed),
    .mode_wide  (mode_wide_q),
    .limit      (limit_q),
    .absorb     (absorb),
    .advance    (advance),
    .word_we    (word_we),
    .word_zero  (word_zero),
    .word_idx   (word_idx),
    .seeded     (seeded),
    .generating (generating),
    .reseeding  (reseeding),
    .gen_done   (gen_done),
    .seed_done  (seed_done)
  );

  // result bank: one write port, no reset, so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (word_we) word_mem[word_idx] <= word_zero ? '0 : mix_word;
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_wide_q <= 1'b0;
      ien_glb     <= 1'b0;
      ien_sd      <= 1'b0;
      ien_rdy     <= 1'b0;
      limit_q     <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(OFS_MODE)) mode_wide_q <= bus_wdata[BIT_WIDE];
      if (bus_addr == ADDR_W'(OFS_IEN)) begin
        ien_glb <= bus_wdata[BIT_IE_GLB];
        ien_sd  <= bus_wdata[BIT_IE_SD];
        ien_rdy <= bus_wdata[BIT_IE_RDY];
      end
      if (bus_addr == ADDR_W'(OFS_LIM)) limit_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // sticky flags: a hardware set wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      iflag_q <= 2'b00;
      irq     <= 1'b0;
    end else begin
      iflag_q[0] <= gen_done  | (iflag_q[0] & ~(wr_iflg & bus_wdata[0]));
      iflag_q[1] <= seed_done | (iflag_q[1] & ~(wr_iflg & bus_wdata[1]));
      irq        <= ien_glb & ((ien_rdy & iflag_q[0]) | (ien_sd & iflag_q[1]));
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (in_out) begin
        bus_rdata <= word_mem[rd_idx];
      end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
        bus_rdata[BIT_SEEDED] <= seeded;
        bus_rdata[BIT_GEN]    <= generating;
        bus_rdata[BIT_RESEED] <= reseeding;
      end else if (bus_addr == ADDR_W'(OFS_MODE)) begin
        bus_rdata[BIT_WIDE] <= mode_wide_q;
      end else if (bus_addr == ADDR_W'(OFS_IEN)) begin
        bus_rdata[BIT_IE_GLB] <= ien_glb;
        bus_rdata[BIT_IE_SD]  <= ien_sd;
        bus_rdata[BIT_IE_RDY] <= ien_rdy;
      end else if (bus_addr == ADDR_W'(OFS_IFLG)) begin
        bus_rdata[1:0] <= iflag_q;
      end else if (bus_addr == ADDR_W'(OFS_LIM)) begin
        bus_rdata <= DATA_W'(limit_q);
      end else if (bus_addr == ADDR_W'(OFS_ID)) begin
        bus_rdata <= DATA_W'(ID_CODE);
      end
    end
  end

endmodule

// File: rtl/seeded_rng_chk.sv
module seeded_rng_chk
  import seeded_rng_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              seeded,
  input logic              generating,
  input logic              gen_done,
  input logic              seed_done,
  input logic [1:0]        iflag,
  input logic              ien_glb,
  input logic              irq,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata
);

  // R1
  seeded_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    seeded |=> seeded);

  // R5
  ready_set_chk: assert property (@(posedge clk) disable iff (rst)
    gen_done |=> iflag[0]);

  // R6
  seed_flag_chk: assert property (@(posedge clk) disable iff (rst)
    seed_done |=> iflag[1]);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ien_glb |=> !irq);

  // R9
  gen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(generating) |=> generating);

  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_ID)) |=> (bus_rdata == DATA_W'(ID_CODE)));

endmodule

bind seeded_rng seeded_rng_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .seeded     (seeded),
  .generating (generating),
  .gen_done   (gen_done),
  .seed_done  (seed_done),
  .iflag      (iflag_q),
  .ien_glb    (ien_glb),
  .irq        (irq),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata)
);

// File: tb/seeded_rng_test.sv
module seeded_rng_test;

  localparam int CLK_PERIOD = 10;
  localparam int SEED_N     = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [31:0] entropy_in = 32'h1357_9BDF;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_state;
  int          m_units;
  int          m_limit;
  logic [31:0] exp_w [8];

  seeded_rng #(.SEED_CYCLES(SEED_N)) uut (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .entropy_in (entropy_in),
    .irq        (irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], 1'b0} ^ (s[31] ? 32'h04C1_1DB7 : 32'h0);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(8'h04, s);
      if (s[31:30] == 2'b00) return;
    end
    check({tag, " timeout"}, s, 32'h0000_0200);
  endtask

  task automatic m_seed();
    for (int i = 0; i < SEED_N; i++) m_state = step(m_state) ^ entropy_in;
    m_units = 0;
  endtask

  task automatic m_gen(input bit wide);
    for (int i = 0; i < 8; i++) begin
      if (!wide && i >= 4) exp_w[i] = 32'h0;
      else begin
        m_state  = step(m_state);
        exp_w[i] = m_state;
      end
    end
    m_units += wide ? 2 : 1;
    if (m_limit != 0 && m_units >= m_limit) m_seed();
  endtask

  task automatic check_words(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(8'h20 + 8'(4 * i), d);
      check(tag, d, exp_w[i]);
    end
  endtask

  task automatic gen(input bit wide, input string tag);
    wr(8'h08, wide ? 32'h8 : 32'h0);
    wr(8'h00, 32'h1);
    wait_idle(tag);
    m_gen(wide);
    check_words(tag);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h04, d);
    check("R1 status during reset seeding", d, 32'h8000_0000);
    wait_idle("R1");
    m_state = 32'h1; m_seed();
    rd(8'h04, d);
    check("R1 seeded after reset", d, 32'h0000_0200);
    rd(8'hF0, d);
    check("R2 id word", d, 32'h0000_46BC);
    rd(8'h14, d);
    check("R6 seed flag after reset", d, 32'h2);
    wr(8'h14, 32'h2);
    rd(8'h14, d);
    check("R6 seed flag cleared", d, 32'h0);
  endtask

  task automatic t_gen();
    logic [31:0] d;
    gen(1'b1, "R3 wide words");
    rd(8'h14, d);
    check("R5 ready set with enables off", d, 32'h1);
    wr(8'h14, 32'h0);
    rd(8'h14, d);
    check("R5 write 0 keeps flag", d, 32'h1);
    wr(8'h14, 32'h1);
    rd(8'h14, d);
    check("R5 write 1 clears flag", d, 32'h0);
    gen(1'b0, "R4 narrow words");
    gen(1'b1, "R3 wide again");
    wr(8'h14, 32'h3);
  endtask

  task automatic t_reseed();
    logic [31:0] d;
    entropy_in = 32'hA5C3_0F96;
    wr(8'h00, 32'h2);
    rd(8'h04, d);
    check("R7 reseeding visible", d, 32'h8000_0200);
    wait_idle("R7");
    m_seed();
    rd(8'h14, d);
    check("R6 seed flag after command", d, 32'h2);
    gen(1'b1, "R7 words after reseed");
    wr(8'h14, 32'h3);
  endtask

  task automatic t_pend();
    logic [31:0] d;
    entropy_in = 32'h0F0F_1234;
    wr(8'h08, 32'h8);
    wr(8'h00, 32'h2);
    wr(8'h00, 32'h1);
    wait_idle("R8");
    m_seed();
    m_gen(1'b1);
    check_words("R8 held generate");
    rd(8'h14, d);
    check("R8 both flags", d, 32'h3);
    wr(8'h14, 32'h3);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    wr(8'h08, 32'h8);
    wr(8'h00, 32'h1);
    wr(8'h00, 32'h2);
    wr(8'h00, 32'h1);
    wait_idle("R9");
    m_gen(1'b1);
    check_words("R9 commands during generate");
    rd(8'h14, d);
    check("R9 no seeding happened", d, 32'h1);
    wr(8'h00, 32'h3);
    rd(8'h04, d);
    check("R9 code 3 ignored", d, 32'h0000_0200);
    wr(8'h00, 32'h2);
    wr(8'h00, 32'h2);
    wait_idle("R9 seed");
    m_seed();
    gen(1'b1, "R9 reseed during seeding");
    wr(8'h14, 32'h3);
  endtask

  task automatic t_auto();
    logic [31:0] d;
    wr(8'h60, 32'd3);
    m_limit = 3;
    rd(8'h60, d);
    check("R12 limit readback", d, 32'd3);
    wr(8'h00, 32'h2);
    wait_idle("R10 pre");
    m_seed();
    wr(8'h14, 32'h3);
    entropy_in = 32'h7777_0001;
    gen(1'b1, "R10 first");
    rd(8'h14, d);
    check("R10 no reseed below limit", d, 32'h1);
    gen(1'b1, "R10 second");
    rd(8'h14, d);
    check("R10 auto reseed at limit", d, 32'h3);
    wr(8'h14, 32'h3);
    gen(1'b1, "R10 words after auto reseed");
    wr(8'h60, 32'd0);
    m_limit = 0;
    gen(1'b1, "R10 disabled a");
    gen(1'b1, "R10 disabled b");
    rd(8'h14, d);
    check("R10 limit 0 no reseed", d, 32'h1);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h10, 32'h0000_0001);
    repeat (2) @(negedge clk);
    check("R11 no global enable", {31'h0, irq}, 32'h0);
    wr(8'h10, 32'h8000_0001);
    repeat (2) @(negedge clk);
    check("R11 ready irq", {31'h0, irq}, 32'h1);
    wr(8'h14, 32'h1);
    repeat (2) @(negedge clk);
    check("R11 irq drops after clear", {31'h0, irq}, 32'h0);
    wr(8'h10, 32'h8000_0002);
    wr(8'h00, 32'h2);
    wait_idle("R11 seed");
    m_seed();
    repeat (2) @(negedge clk);
    check("R11 seed-done irq", {31'h0, irq}, 32'h1);
    rd(8'h10, d);
    check("R11 enable readback", d, 32'h8000_0002);
    wr(8'h14, 32'h3);
  endtask

  task automatic t_bus();
    logic [31:0] d;
    rd(8'h0C, d);
    check("R12 unmapped reads 0", d, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d);
    check("R12 mode keeps bit 3", d, 32'h8);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_units = 0;
    m_limit = 0;
    m_state = 32'h1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_gen();
    t_reseed();
    t_pend();
    t_ignore();
    t_auto();
    t_irq();
    t_bus();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule